// File: doc/BRIEF.md
# Flash Byte-Programming Controller with Lock Levels

This block sits behind the parallel programming port of a small on-chip code store. A mode select and a program strobe choose one of five actions: byte write, byte read, lock-bit write, chip erase or signature read. A byte write starts on the rising edge of the program strobe and then times itself. A chip erase needs the strobe held for a much longer, parameterised window. An active-low busy output tracks each timed operation. While a write runs, a read of that byte shows inverted bit 7, so a programmer can poll for completion.

Three lock bits give four cumulative protection levels. They gate further programming, verify reads and external code fetch. The lock bits cannot be read back. Their effect shows only through the features they block. The store and the lock bits are non-volatile: reset leaves them untouched, and only chip erase clears them.

Top module: `flash_prog_unit`

## Requirements
- R1: During and right after reset, busyN is 1 and dataOut is FFh.
- R2: Mode 3 (erase) with progPin held high for more than ERASE_CYCLES cycles holds busyN low for exactly ERASE_CYCLES cycles. It then sets every byte to FFh and clears all three lock bits.
- R3: If progPin drops during an erase, busyN returns high at the next edge and neither the store nor the lock bits change. busyN stays low for as many cycles as progPin stayed high.
- R4: A rising progPin in mode 1 (byte write) holds busyN low for exactly WRITE_CYCLES cycles. The addressed byte then becomes its old value AND dataIn. A byte write never sets a bit.
- R5: While a byte write is busy, a mode 0 read of that same address gives the complement of the final bit 7 in bit 7 and the old contents in bits 6:0. Once busyN is high again, the read gives the true value.
- R6: In mode 0 (read), dataOut shows the byte at addr one clock after addr is applied.
- R7: In mode 4 (signature), addresses 30h, 31h and 32h read 1Eh, 65h and FFh. Any other address reads 00h.
- R8: A rising progPin while busyN is low is ignored. This holds for write, erase and lock commands alike.
- R9: Mode 2 (lock write) with addr[1:0] set to 1, 2 or 3 sets lock bit 1, 2 or 3 after a busy time of WRITE_CYCLES. With addr[1:0]=0 the busy time is the same but nothing changes. The protection level is cumulative: level 2 needs bit 1, level 3 needs bits 1 and 2, level 4 needs all three. Any other combination is level 1.
- R10: At level 2 or above, a byte write is ignored: busyN stays high and the byte does not change.
- R11: At level 3 or above, a mode 0 read returns FFh. Signature reads still work.
- R12: extFetchEn follows ~extAccessN live at level 1. At levels 2 and 3 it holds the inverse of extAccessN as sampled during the last reset. At level 4 it is 0.
- R13: In modes 5 to 7, progPin edges do nothing and dataOut reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also the sampling window for extAccessN |
| progPin | input | 1 | Program strobe; the rising edge starts a command, and the level is held for erase |
| modeSel | input | 3 | 0 read, 1 byte write, 2 lock write, 3 erase, 4 signature |
| addr | input | ADDR_W | Byte address; bits 1:0 select the lock bit in mode 2 |
| dataIn | input | 8 | Byte to program |
| extAccessN | input | 1 | External-access strap, active low |
| dataOut | output | 8 | Registered readback |
| busyN | output | 1 | Low while a timed operation runs |
| extFetchEn | output | 1 | External code fetch allowed |

## Verification
The bench goes after the AND-only write rule with two overlapping patterns over every address. A design that overwrote bytes instead of clearing bits would miss the second sweep.

The bench polls mid-write. A design that did not invert bit 7, or that kept showing stale data once busy ended, would differ there. It releases an erase early. A design that erased anyway, or ignored the release, would lose data or stay busy too long.

It walks the lock bits out of order and resets between levels. A non-cumulative level decode, or an external-access value that is not latched at reset, shows up as a write that is wrongly accepted or a wrong extFetchEn.

// File: rtl/fpu_pkg.sv
package fpu_pkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] MODE_READ  = 3'd0;
  localparam logic [2:0] MODE_WRITE = 3'd1;
  localparam logic [2:0] MODE_LOCK  = 3'd2;
  localparam logic [2:0] MODE_ERASE = 3'd3;
  localparam logic [2:0] MODE_SIG   = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_LOCK, ST_ERASE} fpu_state_e;

  typedef struct packed {
    logic startWrite;
    logic startLock;
    logic commitWrite;
    logic commitLock;
    logic commitErase;
  } fpu_strobe_t;

  // 0 = unprotected ... 3 = fully locked; only cumulative patterns count
  function automatic logic [1:0] lockLevel(input logic [2:0] lb);
    if (lb[0] && lb[1] && lb[2]) return 2'd3;
    else if (lb[0] && lb[1])     return 2'd2;
    else if (lb[0])              return 2'd1;
    else                         return 2'd0;
  endfunction
endpackage

// File: rtl/fpu_ctrl.sv
module fpu_ctrl
  import fpu_pkg::*;
#(
  parameter int WRITE_CYCLES = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        progPin,
  input  logic [2:0]  modeSel,
  input  logic        writeBlocked,
  output fpu_strobe_t strobes,
  output logic        busy
);
  localparam int MAX_CYC = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] ER_LOAD = CNT_W'(ERASE_CYCLES - 1);

  fpu_state_e       state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             progPrev;
  logic             progRise;

  assign progRise = progPin && !progPrev;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strobes   = '0;
    nextState = state;
    nextCnt   = cnt;
    case (state)
      ST_IDLE: begin
        if (progRise) begin
          case (modeSel)
            MODE_WRITE: if (!writeBlocked) begin
              strobes.startWrite = 1'b1;
              nextState = ST_WRITE;
              nextCnt   = WR_LOAD;
            end
            MODE_LOCK: begin
              strobes.startLock = 1'b1;
              nextState = ST_LOCK;
              nextCnt   = WR_LOAD;
            end
            MODE_ERASE: begin
              nextState = ST_ERASE;
              nextCnt   = ER_LOAD;
            end
            default: ;
          endcase
        end
      end
      ST_WRITE, ST_LOCK: begin
        if (cnt == '0) begin
          strobes.commitWrite = (state == ST_WRITE);
          strobes.commitLock  = (state == ST_LOCK);
          nextState = ST_IDLE;
        end else begin
          nextCnt = cnt - CNT_W'(1);
        end
      end
      ST_ERASE: begin
        if (!progPin) begin
          nextState = ST_IDLE;
        end else if (cnt == '0) begin
          strobes.commitErase = 1'b1;
          nextState = ST_IDLE;
        end else begin
          nextCnt = cnt - CNT_W'(1);
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      progPrev <= 1'b0;
    end else begin
      state    <= nextState;
      cnt      <= nextCnt;
      progPrev <= progPin;
    end
  end

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(progPin) && !$past(progPrev)));

  // R4
  write_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE && cnt != '0) |=> (state == ST_WRITE && cnt == $past(cnt) - CNT_W'(1)));

  // R3
  erase_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE && !progPin) |=> (state == ST_IDLE));
endmodule

// File: rtl/fpu_datapath.sv
module fpu_datapath
  import fpu_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fpu_strobe_t       strobes,
  input  logic [2:0]        modeSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              extAccessN,
  output logic [BYTE_W-1:0] dataOut,
  output logic              extFetchEn,
  output logic              writeBlocked
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] SIG_A0 = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] SIG_A1 = ADDR_W'(8'h31);
  localparam logic [ADDR_W-1:0] SIG_A2 = ADDR_W'(8'h32);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [2:0]        lockBits;
  logic [ADDR_W-1:0] pendAddr;
  logic [BYTE_W-1:0] pendVal;
  logic              pendValid;
  logic [1:0]        lockIdx;
  logic              eaLatch;
  logic [1:0]        level;
  logic [BYTE_W-1:0] readVal;

  assign level        = lockLevel(lockBits);
  assign writeBlocked = (level != 2'd0);
  assign extFetchEn   = (level == 2'd3) ? 1'b0 :
                        (level != 2'd0) ? ~eaLatch : ~extAccessN;

  // non-volatile store: untouched by reset
  always_ff @(posedge clk) begin
    if (strobes.commitErase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strobes.commitWrite) begin
      mem[pendAddr] <= pendVal;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commitErase) lockBits <= '0;
    else if (strobes.commitLock && lockIdx != 2'd0) lockBits[lockIdx - 2'd1] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobes.startWrite) begin
      pendAddr <= addr;
      pendVal  <= mem[addr] & dataIn;
    end
    if (strobes.startLock) lockIdx <= addr[1:0];
    if (!rst_n) eaLatch <= extAccessN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   pendValid <= 1'b0;
    else if (strobes.startWrite)  pendValid <= 1'b1;
    else if (strobes.commitWrite) pendValid <= 1'b0;
  end

  always_comb begin
    readVal = '1;
    case (modeSel)
      MODE_READ: begin
        if (level >= 2'd2)                       readVal = '1;
        else if (pendValid && addr == pendAddr)  readVal = {~pendVal[7], mem[addr][6:0]};
        else                                     readVal = mem[addr];
      end
      MODE_SIG: begin
        if (addr == SIG_A0)      readVal = 8'h1E;
        else if (addr == SIG_A1) readVal = 8'h65;
        else if (addr == SIG_A2) readVal = 8'hFF;
        else                     readVal = 8'h00;
      end
      default: readVal = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dataOut <= '1;
    else        dataOut <= readVal;
  end

  // R2
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.commitErase |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF && lockBits == 3'b000));

  // R4
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.commitWrite |=> ((mem[pendAddr] & ~$past(mem[pendAddr])) == '0));

  // R9
  lock_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.commitErase |=> (($past(lockBits) & ~lockBits) == 3'b000));

  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.startWrite, strobes.startLock, strobes.commitWrite,
              strobes.commitLock, strobes.commitErase}));
endmodule

// File: rtl/flash_prog_unit.sv
module flash_prog_unit
  import fpu_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int WRITE_CYCLES = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              progPin,
  input  logic [2:0]        modeSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic              extAccessN,
  output logic [7:0]        dataOut,
  output logic              busyN,
  output logic              extFetchEn
);
  fpu_strobe_t strobes;
  logic        busy;
  logic        writeBlocked;

  assign busyN = ~busy;

  fpu_ctrl #(.WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .progPin(progPin), .modeSel(modeSel),
    .writeBlocked(writeBlocked), .strobes(strobes), .busy(busy)
  );

  fpu_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .modeSel(modeSel), .addr(addr),
    .dataIn(dataIn), .extAccessN(extAccessN), .dataOut(dataOut),
    .extFetchEn(extFetchEn), .writeBlocked(writeBlocked)
  );
endmodule

// File: tb/flash_prog_unit_bench.sv
module flash_prog_unit_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int WC = 8;
  localparam int EC = 40;
  localparam logic [2:0] M_RD = 3'd0, M_WR = 3'd1, M_LK = 3'd2, M_ER = 3'd3, M_SG = 3'd4;

  logic clk = 0, rst_n = 0, progPin = 0, extAccessN = 0;
  logic [2:0] modeSel = 0;
  logic [AW-1:0] addr = 0;
  logic [7:0] dataIn = 0, dataOut;
  logic busyN, extFetchEn;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [7:0] model [DEPTH];

  always #5 clk = ~clk;

  flash_prog_unit #(.ADDR_W(AW), .WRITE_CYCLES(WC), .ERASE_CYCLES(EC)) u_flash_prog_unit (
    .clk(clk), .rst_n(rst_n), .progPin(progPin), .modeSel(modeSel), .addr(addr),
    .dataIn(dataIn), .extAccessN(extAccessN), .dataOut(dataOut), .busyN(busyN),
    .extFetchEn(extFetchEn));

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runCmd(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d,
                        input int hold, output int lowCnt);
    @(negedge clk);
    modeSel = m; addr = a; dataIn = d; progPin = 1;
    lowCnt = 0;
    for (int i = 0; i < EC + 20; i++) begin
      @(negedge clk);
      if (i == hold - 1) progPin = 0;
      if (!busyN) lowCnt++;
      else break;
    end
    progPin = 0; modeSel = M_RD;
  endtask

  task automatic readByte(input logic [2:0] m, input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    modeSel = m; addr = a;
    @(negedge clk);
    v = dataOut;
  endtask

  task automatic doReset(input logic pin);
    @(negedge clk);
    extAccessN = pin; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic sweepRead(input string req);
    logic [7:0] v;
    for (int a = 0; a < DEPTH; a++) begin
      readByte(M_RD, AW'(a), v);
      check(req, v, model[a]);
    end
  endtask

  task automatic fullErase();
    int lc;
    runCmd(M_ER, '0, 8'h00, EC + 5, lc);
    check("R2 erase busy length", lc, EC);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int lc;
    logic [7:0] v, d;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 busyN", busyN, 1);
    check("R1 dataOut", dataOut, 8'hFF);
    rst_n = 1;
    @(negedge clk);
    check("R1 busyN after", busyN, 1);

    // R2 erase, R6 readback
    fullErase();
    sweepRead("R2/R6 erased");

    // R4 write sweeps, AND semantics
    for (int a = 0; a < DEPTH; a++) begin
      d = 8'((a * 37 + 5) & 255);
      runCmd(M_WR, AW'(a), d, 1, lc);
      check("R4 write busy length", lc, WC);
      model[a] &= d;
    end
    sweepRead("R6 first pattern");
    for (int a = 0; a < DEPTH; a++) begin
      d = 8'(((a * 91 + 60) & 255) ^ 8'hA5);
      runCmd(M_WR, AW'(a), d, 1, lc);
      model[a] &= d;
    end
    sweepRead("R4 and-only second pattern");

    // R5 polling
    @(negedge clk);
    modeSel = M_WR; addr = 5; dataIn = 8'h00; progPin = 1;
    @(negedge clk);
    progPin = 0; modeSel = M_RD; addr = 5;
    @(negedge clk);
    check("R5 poll value", dataOut, {1'b1, model[5][6:0]});
    for (int i = 0; i < 40 && !busyN; i++) @(negedge clk);
    model[5] = 8'h00;
    readByte(M_RD, 5, v);
    check("R5 true after done", v, 8'h00);

    // R8 commands while busy ignored
    @(negedge clk);
    modeSel = M_WR; addr = 10; dataIn = 8'hF0; progPin = 1;
    @(negedge clk);
    progPin = 0;
    @(negedge clk);
    modeSel = M_ER; progPin = 1;
    @(negedge clk);
    progPin = 0; modeSel = M_WR; addr = 11; dataIn = 8'h00;
    @(negedge clk);
    progPin = 1;
    @(negedge clk);
    progPin = 0; modeSel = M_RD;
    for (int i = 0; i < 40 && !busyN; i++) @(negedge clk);
    model[10] &= 8'hF0;
    readByte(M_RD, 10, v);
    check("R8 first write done", v, model[10]);
    readByte(M_RD, 11, v);
    check("R8 write while busy ignored", v, model[11]);
    readByte(M_RD, 12, v);
    check("R8 erase while busy ignored", v, model[12]);

    // R13 unused modes
    for (int m = 5; m < 8; m++) begin
      runCmd(3'(m), 20, 8'h00, 1, lc);
      check("R13 no busy", lc, 0);
      readByte(3'(m), 20, v);
      check("R13 reads FF", v, 8'hFF);
    end
    readByte(M_RD, 20, v);
    check("R13 byte unchanged", v, model[20]);

    // R7 signature
    readByte(M_SG, 6'h30, v); check("R7 sig 30", v, 8'h1E);
    readByte(M_SG, 6'h31, v); check("R7 sig 31", v, 8'h65);
    readByte(M_SG, 6'h32, v); check("R7 sig 32", v, 8'hFF);
    readByte(M_SG, 6'h33, v); check("R7 sig other", v, 8'h00);

    // R3 aborted erase
    runCmd(M_ER, 0, 8'h00, EC / 2, lc);
    check("R3 abort busy length", lc, EC / 2);
    sweepRead("R3 contents kept");

    // R12 level 1 live strap
    extAccessN = 1; @(negedge clk);
    check("R12 level1 live high", extFetchEn, 0);
    extAccessN = 0; @(negedge clk);
    check("R12 level1 live low", extFetchEn, 1);

    // R9 index 0 and bit 2 alone keep level 1
    runCmd(M_LK, 0, 8'h00, 1, lc);
    check("R9 lock idx0 busy", lc, WC);
    runCmd(M_LK, 2, 8'h00, 1, lc);
    check("R9 lock bit2 busy", lc, WC);
    runCmd(M_WR, 21, 8'h0F, 1, lc);
    check("R9 non-cumulative stays level1", lc, WC);
    model[21] &= 8'h0F;

    // clear, then level 2
    fullErase();
    runCmd(M_WR, 7, 8'h5A, 1, lc);
    model[7] = 8'h5A;
    runCmd(M_LK, 1, 8'h00, 1, lc);
    check("R9 lock bit1 busy", lc, WC);
    runCmd(M_WR, 8, 8'h00, 1, lc);
    check("R10 write ignored busy", lc, 0);
    readByte(M_RD, 8, v);
    check("R10 byte unchanged", v, 8'hFF);
    readByte(M_RD, 7, v);
    check("R11 level2 still verifies", v, 8'h5A);
    extAccessN = 1; @(negedge clk);
    check("R12 level2 latched", extFetchEn, 1);
    doReset(1);
    extAccessN = 0; @(negedge clk);
    check("R12 level2 relatched", extFetchEn, 0);

    // level 3
    runCmd(M_LK, 2, 8'h00, 1, lc);
    readByte(M_RD, 7, v);
    check("R11 level3 verify blocked", v, 8'hFF);
    readByte(M_SG, 6'h31, v);
    check("R11 signature at level3", v, 8'h65);
    doReset(0);
    extAccessN = 1; @(negedge clk);
    check("R12 level3 latched", extFetchEn, 1);

    // level 4
    runCmd(M_LK, 3, 8'h00, 1, lc);
    extAccessN = 0; @(negedge clk);
    check("R12 level4 blocks fetch", extFetchEn, 0);

    // erase clears locks
    fullErase();
    @(negedge clk);
    check("R2 locks cleared fetch live", extFetchEn, 1);
    runCmd(M_WR, 7, 8'h33, 1, lc);
    check("R2 writes allowed again", lc, WC);
    readByte(M_RD, 7, v);
    check("R2 verify after erase", v, 8'h33);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule